// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Program Counter and Pipeline Register

This block is the program-counter and inter-stage register logic of a two-stage processor. The fetch stage presents the current program counter on a 32-bit fetch address and receives the instruction word at that address in the same cycle. The word and the address it came from are captured into the execute-stage register, where the rest of the core decodes, executes and writes back in one cycle.

Targets of branches and jumps are resolved only in execute. The execute logic reports a taken branch, a jump, and the resolved target address. Either flag redirects the program counter to the target on the next edge. It also replaces the word fetched in that cycle with the all-zero no-operation word before it reaches execute, and it clears the address carried with that word. An untaken branch is simply the absence of the branch flag and never removes an instruction. After reset the execute register holds the all-zero word, so the first execute cycle does nothing.

Top module: `fetch_exec_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the fetch address is 0, the execute instruction is 0x00000000 and the execute PC is 0.
- R2: In a cycle with neither the jump flag nor the branch-taken flag set, the next fetch address is the current fetch address plus 4.
- R3: In a cycle with neither flag set, the instruction word on the input and the current fetch address appear on the execute instruction and execute PC outputs one cycle later, unchanged.
- R4: In a cycle with the jump flag set, the next fetch address equals the target input, and the execute instruction one cycle later is 0x00000000.
- R5: In a cycle with the branch-taken flag set, the next fetch address equals the target input, and the execute instruction one cycle later is 0x00000000.
- R6: When both flags are set in the same cycle, exactly one redirect takes place: the next fetch address is the target and the execute instruction one cycle later is 0x00000000.
- R7: In the cycle after any redirect, the execute PC is 0.
- R8: The link output always equals the execute PC plus 4, modulo 2^32.
- R9: The program counter wraps modulo 2^32: from a fetch address of 0xFFFFFFFC with no redirect, the next fetch address is 0; a target is taken verbatim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state, ungated |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word at the current fetch address |
| br_taken_i | input | 1 | Execute stage has a branch whose condition holds |
| jump_i | input | 1 | Execute stage has a jump |
| target_i | input | 32 | Redirect address resolved in execute |
| fetch_addr_o | output | 32 | Address of the instruction being fetched |
| ex_instr_o | output | 32 | Instruction word held for execute |
| ex_pc_o | output | 32 | Address of the instruction held for execute |
| ex_link_o | output | 32 | Execute PC plus 4, the return address |

## Verification
The two functions that can fall in the same cycle are a taken branch and a jump, both asking for a redirect; the random stimulus raises each flag independently so that the pair coincides regularly, and a directed step sets both at once right after reset. Such a cycle is judged by a single target load and a single nop insertion, with no extra cycle lost and no stale word leaking into execute. A directed jump to the top of the address space followed by quiet cycles checks the wrap to zero.

// File: rtl/fec_pkg.sv
package fec_pkg;

  // Source of the next program counter.
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } pc_src_e;

  // The no-operation word swapped in for a removed instruction.
  localparam logic [31:0] NOP_WORD = 32'h0000_0000;

endpackage

// File: rtl/fec_next_pc.sv
module fec_next_pc
  import fec_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned STEP = 4
) (
  input  logic [XLEN-1:0] pc_q,
  input  logic            br_taken,
  input  logic            jump,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc_d,
  output logic            kill,
  output pc_src_e         src
);

  function automatic logic [XLEN-1:0] pc_step(input logic [XLEN-1:0] pc);
    return pc + XLEN'(STEP);
  endfunction

  // A jump wins the label when both flags are set; the target is the same.
  always_comb begin
    if (jump)          src = SRC_JUMP;
    else if (br_taken) src = SRC_BRANCH;
    else               src = SRC_SEQ;
  end

  assign kill = (src != SRC_SEQ);

  always_comb begin
    unique case (src)
      SRC_JUMP, SRC_BRANCH: pc_d = target;
      default:              pc_d = pc_step(pc_q);
    endcase
  end

endmodule

// File: rtl/fec_pc_reg.sv
module fec_pc_reg #(
  parameter int unsigned XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_d,
  output logic [XLEN-1:0] pc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= XLEN'(RESET_PC);
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/fec_exec_latch.sv
module fec_exec_latch
  import fec_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned ILEN = 32,
  parameter int unsigned STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kill,
  input  logic [ILEN-1:0] fetch_word,
  input  logic [XLEN-1:0] fetch_pc,
  output logic [ILEN-1:0] ex_word,
  output logic [XLEN-1:0] ex_pc,
  output logic [XLEN-1:0] ex_link
);

  logic [ILEN-1:0] word_d;
  logic [XLEN-1:0] pc_d;

  // Kill multiplexer: the wrong-path word and its address are dropped.
  assign word_d = kill ? ILEN'(NOP_WORD) : fetch_word;
  assign pc_d   = kill ? '0 : fetch_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_word <= ILEN'(NOP_WORD);
      ex_pc   <= '0;
    end else begin
      ex_word <= word_d;
      ex_pc   <= pc_d;
    end
  end

  assign ex_link = ex_pc + XLEN'(STEP);

  AST_PASS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !kill |=> (ex_word == $past(fetch_word)) && (ex_pc == $past(fetch_pc))); // R3

  AST_KILL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (ex_word == '0)); // R4

  AST_KILL_PC: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (ex_pc == '0)); // R7

endmodule

// File: rtl/fetch_exec_ctrl.sv
module fetch_exec_ctrl
  import fec_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned ILEN     = 32,
  parameter int unsigned STEP     = 4,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ILEN-1:0] instr_i,
  input  logic            br_taken_i,
  input  logic            jump_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] fetch_addr_o,
  output logic [ILEN-1:0] ex_instr_o,
  output logic [XLEN-1:0] ex_pc_o,
  output logic [XLEN-1:0] ex_link_o
);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic            kill_w;
  pc_src_e         src_w;

  fec_next_pc #(.XLEN(XLEN), .STEP(STEP)) u_next (
    .pc_q     (pc_q),
    .br_taken (br_taken_i),
    .jump     (jump_i),
    .target   (target_i),
    .pc_d     (pc_d),
    .kill     (kill_w),
    .src      (src_w)
  );

  fec_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .pc_d  (pc_d),
    .pc_q  (pc_q)
  );

  assign fetch_addr_o = pc_q;

  fec_exec_latch #(.XLEN(XLEN), .ILEN(ILEN), .STEP(STEP)) u_ex (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill       (kill_w),
    .fetch_word (instr_i),
    .fetch_pc   (pc_q),
    .ex_word    (ex_instr_o),
    .ex_pc      (ex_pc_o),
    .ex_link    (ex_link_o)
  );

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_taken_i && !jump_i) |=> (fetch_addr_o == $past(fetch_addr_o) + XLEN'(4))); // R2

  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken_i || jump_i) |=> (fetch_addr_o == $past(target_i))); // R5

  AST_DUAL_ONE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken_i && jump_i) |=> (ex_instr_o == '0 && fetch_addr_o == $past(target_i))); // R6

  AST_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ex_pc_o) |-> $stable(ex_link_o)); // R8

  AST_KILL_ONLY_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    kill_w |-> (br_taken_i || jump_i)); // R4

endmodule

// File: tb/fetch_exec_ctrl_tb.sv
module fetch_exec_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i;
  logic        br_taken_i = 1'b0;
  logic        jump_i = 1'b0;
  logic [31:0] target_i = '0;
  logic [31:0] fetch_addr_o, ex_instr_o, ex_pc_o, ex_link_o;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model state
  logic [31:0] m_pc = '0;
  logic [31:0] m_ir = '0;
  logic [31:0] m_expc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_exec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .br_taken_i(br_taken_i),
    .jump_i(jump_i), .target_i(target_i), .fetch_addr_o(fetch_addr_o),
    .ex_instr_o(ex_instr_o), .ex_pc_o(ex_pc_o), .ex_link_o(ex_link_o)
  );

  // Instruction memory image: a pure function of the address.
  function automatic logic [31:0] imem(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  always_comb instr_i = imem(fetch_addr_o);

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // One cycle: drive at the falling edge, model the edge, check at the next fall.
  task automatic step(input logic br, input logic jp, input logic [31:0] tgt);
    logic redir;
    logic [31:0] n_pc, n_ir, n_expc;
    string tag_f, tag_i, tag_p;
    br_taken_i = br;
    jump_i     = jp;
    target_i   = tgt;
    redir  = br | jp;
    n_pc   = redir ? tgt : m_pc + 32'd4;
    n_ir   = redir ? 32'h0 : imem(m_pc);
    n_expc = redir ? 32'h0 : m_pc;
    if (br && jp)   tag_f = "R6";
    else if (jp)    tag_f = "R4";
    else if (br)    tag_f = "R5";
    else if (m_pc == 32'hFFFF_FFFC) tag_f = "R9";
    else            tag_f = "R2";
    tag_i = redir ? tag_f : "R3";
    tag_p = redir ? "R7" : "R3";
    @(posedge clk);
    m_pc = n_pc; m_ir = n_ir; m_expc = n_expc;
    @(negedge clk);
    chk(tag_f, "fetch_addr", fetch_addr_o, m_pc);
    chk(tag_i, "ex_instr", ex_instr_o, m_ir);
    chk(tag_p, "ex_pc", ex_pc_o, m_expc);
    chk("R8", "ex_link", ex_link_o, m_expc + 32'd4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [31:0] r;
    seed = 32'd20171106;
    r = $urandom(seed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "fetch_addr in reset", fetch_addr_o, 32'h0);
    chk("R1", "ex_instr in reset", ex_instr_o, 32'h0);
    rst_n = 1'b1;
    chk("R1", "fetch_addr after reset", fetch_addr_o, 32'h0);
    chk("R1", "ex_instr after reset", ex_instr_o, 32'h0);
    chk("R1", "ex_pc after reset", ex_pc_o, 32'h0);

    // Directed: both flags at once right after reset (R6)
    step(1'b1, 1'b1, 32'h0000_0100);
    step(1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b0, 32'h0);
    // Directed: jump to the top of the space, then wrap (R9)
    step(1'b0, 1'b1, 32'hFFFF_FFF8);
    step(1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b0, 32'h0);
    // Directed: back-to-back taken branches (R5), unaligned target verbatim (R9)
    step(1'b1, 1'b0, 32'h0000_2002);
    step(1'b1, 1'b0, 32'h0000_3000);
    step(1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b1, 32'h0000_0040);
    step(1'b0, 1'b0, 32'h0);

    for (int i = 0; i < N_RANDOM; i++) begin
      logic b, j;
      logic [31:0] t;
      b = ($urandom % 6) == 0;
      j = ($urandom % 8) == 0;
      t = ($urandom % 5 == 0) ? $urandom : ($urandom & 32'h0000_FFFC);
      step(b, j, t);
    end

    finish_run();
  end

endmodule